// File: doc/BRIEF.md
# Eight-bit ALU with condition codes

This block is the combinational arithmetic and logic unit of an accumulator-style eight-bit processor core. It receives an operation code, a primary operand, a secondary operand, and the incoming carry and half-carry flags. Within one cycle it returns the result byte, a write strobe, five status flags (half carry, negative, zero, overflow, carry) and a per-flag update mask. The mask tells the surrounding core which bits of its condition-code register to overwrite. Flags outside the mask are driven to 0 and must be ignored.

Each operation has its own flag rule. Some flags are computed, some are forced to a fixed value, and the rest are left for the core to keep. The unit covers binary add and subtract with and without the incoming carry, compare, the bitwise operations, shifts and rotates through carry, and a packed-BCD decimal adjust of the primary operand. Operand fetch, register storage and sixteen-bit work belong to the surrounding core.

Top module: `alu8_core`

## Requirements
- R1: Op ADD (0) gives a+b and op ADC (1) gives a+b+c_i. Both update all five flags. H is the carry out of bit 3, C is the carry out of bit 7, and V is two's-complement overflow.
- R2: Op SUB (2) gives a-b and op SBC (3) gives a-b-c_i. Both update N, Z, V and C, and H is not updated. C is 1 exactly when b plus the borrow-in exceeds a as unsigned numbers.
- R3: Op CMP (4) produces the same flags and the same result byte as SUB, but wr_o is 0.
- R4: Ops AND (5), OR (6), EOR (7), BIT (8), LD (15) and TST (14) update N and Z, force V to 0, and update neither C nor H (mask 0x0E). LD returns b, and TST returns a. BIT (which returns a&b) and TST have wr_o at 0.
- R5: Op COM (9) returns the bitwise inverse of a, forces C to 1 and V to 0, and updates N and Z.
- R6: Op CLR (13) returns 0 with N=0, Z=1, V=0 and C=0 (mask 0x0F), whatever the inputs.
- R7: Op NEG (10) returns 0-a and updates N, Z, V and C. C is 1 whenever a is non-zero, and V is 1 only for a=0x80.
- R8: Op INC (11) returns a+1 and op DEC (12) returns a-1. Both update N, Z and V but not C. V is set on 0x7F to 0x80 for INC and on 0x80 to 0x7F for DEC.
- R9: Op ASL (16) shifts a left, moves bit 7 into C, sets V to bit 7 XOR bit 6 of a, and updates N, Z, V and C. Op ASR (17) shifts a right keeping bit 7, moves bit 0 into C, and updates N, Z and C.
- R10: Op LSR (18) shifts a right with a 0 into bit 7. N is forced to 0, C receives bit 0, and N, Z and C are updated.
- R11: Op ROL (19) moves c_i into bit 0 and bit 7 into C, sets V to the new N XOR the new C, and updates N, Z, V and C. Op ROR (20) moves c_i into bit 7 and bit 0 into C, and updates N, Z and C.
- R12: Op DAA (21) adds 0x06 when the low nibble exceeds 9 or h_i is 1. It adds 0x60 when c_i is 1, when the high nibble exceeds 9, or when the high nibble exceeds 8 and the low nibble exceeds 9. C is 1 exactly when 0x60 was added, V is 0, and N, Z, V and C are updated.
- R13: Flag vectors place H, N, Z, V and C at bits 4 down to 0. Every flag bit outside upd_o reads 0. Any op code from 22 to 31 returns a with wr_o at 0 and upd_o at 0.
- R14: Whenever Z is in the mask it equals (res_o==0), and whenever N is in the mask it equals res_o bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Primary operand (the only operand of unary ops) |
| b_i | input | 8 | Secondary operand |
| c_i | input | 1 | Incoming carry flag |
| h_i | input | 1 | Incoming half-carry flag (used by DAA) |
| res_o | output | 8 | Result byte |
| wr_o | output | 1 | Result should be written back |
| flags_o | output | 5 | New flag values {H,N,Z,V,C} |
| upd_o | output | 5 | Flags to update {H,N,Z,V,C} |

## Verification
The bound checker evaluates several rules on every input change:
- Z and N agree with the result byte whenever they are in the mask.
- The logic group always has mask 0x0E with V low.
- Compare never raises the write strobe, and increment and decrement never touch carry.
- The add half carry matches an independent nibble sum.
- Clear always yields its fixed flag set.

The exact results are shown only by the directed scenarios, because they need chosen operand values. These cover the borrow, overflow and rotate-carry values, the inverse-and-set-carry of complement, and the decimal-adjust corrections at their nibble thresholds.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW  = 8;
    localparam int NW  = DW / 2;
    localparam int OPW = 5;
    localparam int NF  = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
        OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_EOR = 5'd7,
        OP_BIT = 5'd8,  OP_COM = 5'd9,  OP_NEG = 5'd10, OP_INC = 5'd11,
        OP_DEC = 5'd12, OP_CLR = 5'd13, OP_TST = 5'd14, OP_LD  = 5'd15,
        OP_ASL = 5'd16, OP_ASR = 5'd17, OP_LSR = 5'd18, OP_ROL = 5'd19,
        OP_ROR = 5'd20, OP_DAA = 5'd21
    } alu_op_e;

    typedef enum logic [2:0] {
        U_ARITH, U_LOGIC, U_SHIFT, U_DAA, U_NONE
    } unit_e;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccf_t;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          wr;
        ccf_t          f;
        ccf_t          upd;
    } alu_out_t;

    localparam ccf_t UPD_NONE = '{h: 1'b0, n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};
    localparam ccf_t UPD_ALL  = '{h: 1'b1, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b1};
    localparam ccf_t UPD_NZVC = '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b1};
    localparam ccf_t UPD_NZV  = '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b0};
    localparam ccf_t UPD_NZC  = '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b0, c: 1'b1};

    function automatic unit_e op_unit(input alu_op_e op);
        unit_e u;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP,
            OP_NEG, OP_INC, OP_DEC:                   u = U_ARITH;
            OP_AND, OP_OR, OP_EOR, OP_BIT, OP_COM,
            OP_CLR, OP_TST, OP_LD:                    u = U_LOGIC;
            OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR:   u = U_SHIFT;
            OP_DAA:                                   u = U_DAA;
            default:                                  u = U_NONE;
        endcase
        return u;
    endfunction

    function automatic logic is_zero(input logic [DW-1:0] v);
        return (v == '0);
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
(
    input  alu_op_e       op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          c_i,
    output alu_out_t      out_o
);

    logic [DW-1:0] x, y, r;
    logic          ci, is_sub;
    logic [DW:0]   wide;
    logic [NW:0]   nib;
    logic          ovf;

    always_comb begin
        x      = a_i;
        y      = b_i;
        ci     = 1'b0;
        is_sub = 1'b0;
        case (op_i)
            OP_ADC:         ci = c_i;
            OP_SUB, OP_CMP: is_sub = 1'b1;
            OP_SBC: begin
                is_sub = 1'b1;
                ci     = c_i;
            end
            OP_NEG: begin
                is_sub = 1'b1;
                x      = '0;
                y      = a_i;
            end
            OP_INC:         y = DW'(1);
            OP_DEC: begin
                is_sub = 1'b1;
                y      = DW'(1);
            end
            default: ;
        endcase
    end

    always_comb begin
        if (is_sub) begin
            wide = {1'b0, x} - {1'b0, y} - {{DW{1'b0}}, ci};
            nib  = {1'b0, x[NW-1:0]} - {1'b0, y[NW-1:0]} - {{NW{1'b0}}, ci};
        end else begin
            wide = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};
            nib  = {1'b0, x[NW-1:0]} + {1'b0, y[NW-1:0]} + {{NW{1'b0}}, ci};
        end
        r = wide[DW-1:0];
        if (is_sub)
            ovf = (x[DW-1] != y[DW-1]) && (r[DW-1] != x[DW-1]);
        else
            ovf = (x[DW-1] == y[DW-1]) && (r[DW-1] != x[DW-1]);
    end

    always_comb begin
        out_o.res   = r;
        out_o.wr    = (op_i != OP_CMP);
        out_o.f.h   = nib[NW];
        out_o.f.n   = r[DW-1];
        out_o.f.z   = is_zero(r);
        out_o.f.v   = ovf;
        out_o.f.c   = wide[DW];
        case (op_i)
            OP_ADD, OP_ADC:                 out_o.upd = UPD_ALL;
            OP_SUB, OP_SBC, OP_CMP, OP_NEG: out_o.upd = UPD_NZVC;
            OP_INC, OP_DEC:                 out_o.upd = UPD_NZV;
            default:                        out_o.upd = UPD_NONE;
        endcase
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
(
    input  alu_op_e       op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output alu_out_t      out_o
);

    logic [DW-1:0] r;

    always_comb begin
        case (op_i)
            OP_AND, OP_BIT: r = a_i & b_i;
            OP_OR:          r = a_i | b_i;
            OP_EOR:         r = a_i ^ b_i;
            OP_COM:         r = ~a_i;
            OP_CLR:         r = '0;
            OP_LD:          r = b_i;
            default:        r = a_i;
        endcase
    end

    always_comb begin
        out_o.res = r;
        out_o.wr  = !(op_i == OP_BIT || op_i == OP_TST);
        out_o.f.h = 1'b0;
        out_o.f.n = r[DW-1];
        out_o.f.z = is_zero(r);
        out_o.f.v = 1'b0;
        out_o.f.c = (op_i == OP_COM);
        if (op_i == OP_COM || op_i == OP_CLR)
            out_o.upd = UPD_NZVC;
        else
            out_o.upd = UPD_NZV;
    end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
(
    input  alu_op_e       op_i,
    input  logic [DW-1:0] a_i,
    input  logic          c_i,
    output alu_out_t      out_o
);

    logic [DW-1:0] r;
    logic          co, vo;
    ccf_t          upd;

    always_comb begin
        r   = a_i;
        co  = 1'b0;
        vo  = 1'b0;
        upd = UPD_NZC;
        case (op_i)
            OP_ASL: begin
                r   = {a_i[DW-2:0], 1'b0};
                co  = a_i[DW-1];
                vo  = a_i[DW-1] ^ a_i[DW-2];
                upd = UPD_NZVC;
            end
            OP_ASR: begin
                r  = {a_i[DW-1], a_i[DW-1:1]};
                co = a_i[0];
            end
            OP_LSR: begin
                r  = {1'b0, a_i[DW-1:1]};
                co = a_i[0];
            end
            OP_ROL: begin
                r   = {a_i[DW-2:0], c_i};
                co  = a_i[DW-1];
                vo  = a_i[DW-2] ^ a_i[DW-1];
                upd = UPD_NZVC;
            end
            OP_ROR: begin
                r  = {c_i, a_i[DW-1:1]};
                co = a_i[0];
            end
            default: upd = UPD_NONE;
        endcase
    end

    always_comb begin
        out_o.res = r;
        out_o.wr  = 1'b1;
        out_o.f.h = 1'b0;
        out_o.f.n = r[DW-1];
        out_o.f.z = is_zero(r);
        out_o.f.v = vo;
        out_o.f.c = co;
        out_o.upd = upd;
    end

endmodule

// File: rtl/alu8_daa.sv
module alu8_daa
    import alu8_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  logic          c_i,
    input  logic          h_i,
    output alu_out_t      out_o
);

    localparam logic [NW-1:0] BCD_MAX = NW'(9);
    localparam logic [NW-1:0] BCD_HI8 = NW'(8);
    localparam logic [NW-1:0] FIX     = NW'(6);

    logic [NW-1:0] lo, hi;
    logic          fix_lo, fix_hi;
    logic [DW-1:0] corr, r;

    always_comb begin
        lo     = a_i[NW-1:0];
        hi     = a_i[DW-1:NW];
        fix_lo = h_i || (lo > BCD_MAX);
        fix_hi = c_i || (hi > BCD_MAX) || ((hi > BCD_HI8) && (lo > BCD_MAX));
        corr   = {(fix_hi ? FIX : '0), (fix_lo ? FIX : '0)};
        r      = a_i + corr;
    end

    always_comb begin
        out_o.res = r;
        out_o.wr  = 1'b1;
        out_o.f.h = 1'b0;
        out_o.f.n = r[DW-1];
        out_o.f.z = is_zero(r);
        out_o.f.v = 1'b0;
        out_o.f.c = fix_hi;
        out_o.upd = UPD_NZVC;
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [OPW-1:0] op_i,
    input  logic [DW-1:0]  a_i,
    input  logic [DW-1:0]  b_i,
    input  logic           c_i,
    input  logic           h_i,
    output logic [DW-1:0]  res_o,
    output logic           wr_o,
    output logic [NF-1:0]  flags_o,
    output logic [NF-1:0]  upd_o
);

    localparam int NU = 4;

    alu_op_e  op;
    alu_out_t unit_out [NU];
    alu_out_t sel;
    unit_e    u;

    assign op = alu_op_e'(op_i);
    assign u  = op_unit(op);

    alu8_arith u_arith (.op_i(op), .a_i(a_i), .b_i(b_i), .c_i(c_i), .out_o(unit_out[0]));
    alu8_logic u_logic (.op_i(op), .a_i(a_i), .b_i(b_i),            .out_o(unit_out[1]));
    alu8_shift u_shift (.op_i(op), .a_i(a_i), .c_i(c_i),            .out_o(unit_out[2]));
    alu8_daa   u_daa   (.a_i(a_i), .c_i(c_i), .h_i(h_i),            .out_o(unit_out[3]));

    always_comb begin
        case (u)
            U_ARITH: sel = unit_out[0];
            U_LOGIC: sel = unit_out[1];
            U_SHIFT: sel = unit_out[2];
            U_DAA:   sel = unit_out[3];
            default: begin
                sel.res = a_i;
                sel.wr  = 1'b0;
                sel.f   = UPD_NONE;
                sel.upd = UPD_NONE;
            end
        endcase
    end

    assign res_o   = sel.res;
    assign wr_o    = sel.wr;
    assign upd_o   = sel.upd;
    assign flags_o = sel.f & sel.upd;

endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
    import alu8_pkg::*;
(
    input logic [OPW-1:0] op_i,
    input logic [DW-1:0]  a_i,
    input logic [DW-1:0]  b_i,
    input logic [DW-1:0]  res_o,
    input logic           wr_o,
    input logic [NF-1:0]  flags_o,
    input logic [NF-1:0]  upd_o
);

    logic [NW:0] lo_sum;
    logic        known;

    always_comb begin
        lo_sum = {1'b0, a_i[NW-1:0]} + {1'b0, b_i[NW-1:0]};
        known  = !$isunknown({op_i, a_i, b_i, res_o, wr_o, flags_o, upd_o});
        if (known) begin
            // R14
            z_match_chk: assert (!upd_o[2] || (flags_o[2] == (res_o == '0)));
            // R14
            n_match_chk: assert (!upd_o[3] || (flags_o[3] == res_o[DW-1]));
            // R3
            cmp_nowr_chk: assert (op_i != OP_CMP || !wr_o);
            // R8
            incdec_keepc_chk: assert (!(op_i == OP_INC || op_i == OP_DEC) || !upd_o[0]);
            // R4
            logic_mask_chk: assert (!(op_i == OP_AND || op_i == OP_OR || op_i == OP_EOR ||
                                      op_i == OP_BIT || op_i == OP_LD || op_i == OP_TST)
                                    || (upd_o == 5'b01110 && !flags_o[1]));
            // R1
            add_half_chk: assert (op_i != OP_ADD || (upd_o[4] && flags_o[4] == lo_sum[NW]));
            // R6
            clr_fixed_chk: assert (op_i != OP_CLR || (res_o == '0 && flags_o[3:0] == 4'b0100));
        end
    end

endmodule

bind alu8_core alu8_chk chk_i (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .res_o(res_o),
    .wr_o(wr_o), .flags_o(flags_o), .upd_o(upd_o)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb_top;
    import alu8_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] op_i = 5'd31;
    logic [7:0] a_i = '0, b_i = '0;
    logic       c_i = 1'b0, h_i = 1'b0;
    logic [7:0] res_o;
    logic       wr_o;
    logic [4:0] flags_o, upd_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_core dut_i (
        .op_i(op_i), .a_i(a_i), .b_i(b_i), .c_i(c_i), .h_i(h_i),
        .res_o(res_o), .wr_o(wr_o), .flags_o(flags_o), .upd_o(upd_o)
    );

    task automatic chk(input string tag, input logic [4:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic c, input logic h,
                       input logic [7:0] er, input logic ew,
                       input logic [4:0] ef, input logic [4:0] eu);
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; c_i = c; h_i = h;
        #1;
        checks++;
        if (res_o !== er || wr_o !== ew || flags_o !== ef || upd_o !== eu) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h: got res=%h wr=%b f=%b u=%b exp res=%h wr=%b f=%b u=%b",
                     tag, op, a, b, res_o, wr_o, flags_o, upd_o, er, ew, ef, eu);
        end
    endtask

    task automatic t_idle();
        chk("R13 idle", 5'd31, 8'h33, 8'h44, 1'b1, 1'b1, 8'h33, 1'b0, 5'h00, 5'h00);
        chk("R13 op22", 5'd22, 8'hA5, 8'h00, 1'b0, 1'b0, 8'hA5, 1'b0, 5'h00, 5'h00);
    endtask

    task automatic t_add();
        chk("R1 add half", OP_ADD, 8'h08, 8'h08, 1'b1, 1'b0, 8'h10, 1'b1, 5'h10, 5'h1F);
        chk("R1 add ovf",  OP_ADD, 8'h7F, 8'h01, 1'b0, 1'b0, 8'h80, 1'b1, 5'h1A, 5'h1F);
        chk("R1 adc wrap", OP_ADC, 8'hFF, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 5'h15, 5'h1F);
    endtask

    task automatic t_sub();
        chk("R2 sub borrow", OP_SUB, 8'h05, 8'h07, 1'b0, 1'b0, 8'hFE, 1'b1, 5'h09, 5'h0F);
        chk("R2 sbc ovf",    OP_SBC, 8'h80, 8'h00, 1'b1, 1'b0, 8'h7F, 1'b1, 5'h02, 5'h0F);
        chk("R3 cmp equal",  OP_CMP, 8'h42, 8'h42, 1'b1, 1'b0, 8'h00, 1'b0, 5'h04, 5'h0F);
    endtask

    task automatic t_logic();
        chk("R4 and",  OP_AND, 8'hF0, 8'h0F, 1'b1, 1'b1, 8'h00, 1'b1, 5'h04, 5'h0E);
        chk("R4 or",   OP_OR,  8'h80, 8'h01, 1'b0, 1'b0, 8'h81, 1'b1, 5'h08, 5'h0E);
        chk("R4 eor",  OP_EOR, 8'hFF, 8'h0F, 1'b0, 1'b0, 8'hF0, 1'b1, 5'h08, 5'h0E);
        chk("R4 bit",  OP_BIT, 8'h80, 8'h80, 1'b0, 1'b0, 8'h80, 1'b0, 5'h08, 5'h0E);
        chk("R4 ld",   OP_LD,  8'h55, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 5'h04, 5'h0E);
        chk("R4 tst",  OP_TST, 8'h00, 8'h77, 1'b1, 1'b0, 8'h00, 1'b0, 5'h04, 5'h0E);
        chk("R5 com",  OP_COM, 8'h00, 8'h00, 1'b0, 1'b0, 8'hFF, 1'b1, 5'h09, 5'h0F);
        chk("R6 clr",  OP_CLR, 8'h99, 8'hFF, 1'b1, 1'b1, 8'h00, 1'b1, 5'h04, 5'h0F);
    endtask

    task automatic t_unary();
        chk("R7 neg 80", OP_NEG, 8'h80, 8'h00, 1'b0, 1'b0, 8'h80, 1'b1, 5'h0B, 5'h0F);
        chk("R7 neg 00", OP_NEG, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 5'h04, 5'h0F);
        chk("R8 inc 7f", OP_INC, 8'h7F, 8'h00, 1'b1, 1'b0, 8'h80, 1'b1, 5'h0A, 5'h0E);
        chk("R8 inc ff", OP_INC, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 5'h04, 5'h0E);
        chk("R8 dec 80", OP_DEC, 8'h80, 8'h00, 1'b1, 1'b0, 8'h7F, 1'b1, 5'h02, 5'h0E);
        chk("R8 dec 01", OP_DEC, 8'h01, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 5'h04, 5'h0E);
    endtask

    task automatic t_shift();
        chk("R9 asl 40",  OP_ASL, 8'h40, 8'h00, 1'b0, 1'b0, 8'h80, 1'b1, 5'h0A, 5'h0F);
        chk("R9 asl 81",  OP_ASL, 8'h81, 8'h00, 1'b0, 1'b0, 8'h02, 1'b1, 5'h03, 5'h0F);
        chk("R9 asr 81",  OP_ASR, 8'h81, 8'h00, 1'b0, 1'b0, 8'hC0, 1'b1, 5'h09, 5'h0D);
        chk("R10 lsr 81", OP_LSR, 8'h81, 8'h00, 1'b1, 1'b0, 8'h40, 1'b1, 5'h01, 5'h0D);
        chk("R10 lsr 01", OP_LSR, 8'h01, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 5'h05, 5'h0D);
        chk("R11 rol 80", OP_ROL, 8'h80, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 5'h07, 5'h0F);
        chk("R11 rol 40", OP_ROL, 8'h40, 8'h00, 1'b1, 1'b0, 8'h81, 1'b1, 5'h0A, 5'h0F);
        chk("R11 ror 01", OP_ROR, 8'h01, 8'h00, 1'b1, 1'b0, 8'h80, 1'b1, 5'h09, 5'h0D);
    endtask

    task automatic t_daa();
        chk("R12 daa lo",   OP_DAA, 8'h1A, 8'h00, 1'b0, 1'b0, 8'h20, 1'b1, 5'h00, 5'h0F);
        chk("R12 daa both", OP_DAA, 8'h9A, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 5'h05, 5'h0F);
        chk("R12 daa h",    OP_DAA, 8'h02, 8'h00, 1'b0, 1'b1, 8'h08, 1'b1, 5'h00, 5'h0F);
        chk("R12 daa c",    OP_DAA, 8'h15, 8'h00, 1'b1, 1'b0, 8'h75, 1'b1, 5'h01, 5'h0F);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        t_idle();
        t_add();
        t_sub();
        t_logic();
        t_unary();
        t_shift();
        t_daa();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule